// File: doc/BRIEF.md
# Seconds Timer with Alarm

A free-running elapsed-time counter for a chip's always-on housekeeping area. A slow reference tick (nominally 32.768 kHz, delivered as a one-cycle enable on the system clock) feeds a programmable divider. Each time the divider completes a period, a 32-bit counter steps by one. With the default divider value of 32768 the counter therefore counts seconds.

A programmable alarm value is compared against the counter as it steps. Two sticky event flags record that the alarm was reached and that the counter stepped. Each flag can drive the single interrupt line through its own enable. Software sees four word registers on a simple read/write strobe bus: mode, alarm, count and events. The count cannot be loaded. It can only be returned to zero with a self-clearing restart command. Reading the event register clears it.

Top module: `sec_timer`

## Requirements
- R1: After reset the mode register reads 0x00008000 (divider period 0x8000 in bits 15:0, both interrupt enables in bits 16 and 17 clear), the alarm register reads all ones, the count and event registers read 0, and `irq_o` is low.
- R2: Registers are selected by byte address bits 3:2: 0x00 mode, 0x04 alarm, 0x08 count, 0x0C events. Bits 1:0 are ignored. Read data appears on `bus_rdata_o` on the cycle after the read strobe.
- R3: With divider period P in mode bits 15:0 (P = 0 means 65536), the count after a restart followed by N slow ticks equals floor(N / P). The reset value 0x8000 gives one step per 32768 ticks.
- R4: Writing the mode register with bit 18 set returns the divider and the count to zero, without touching the event flags. Bit 18 and bits 31:19 always read 0.
- R5: The count and event registers are read-only: writes to 0x08 and 0x0C change neither of them.
- R6: The count wraps from all ones to zero on the next step.
- R7: Event bit 1 sets on every counter step. Event bit 0 sets on the step whose new count equals the alarm value. Both stay set until read.
- R8: An alarm value of all ones never sets event bit 0.
- R9: A read of the event register returns its current value and clears both bits. An event raised on the same edge as that read remains set.
- R10: `irq_o` is high exactly when (event bit 0 and mode bit 16) or (event bit 1 and mode bit 17). It follows the same clock edge that updates the events or the enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick_i | input | 1 | One-cycle enable per slow reference period |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A slow tick, a register write and a restart all take effect on the clock edge that samples them. The count, the event flags and `irq_o` have their new values right after that edge. Read data is due one edge after the read strobe. The bench drives every input at the falling edge and samples results at the next falling edge, so each check lands half a cycle after the edge that produced it. Slow ticks are issued only in counted bursts, which makes the expected count floor(N / P) exact, whatever the reads in between.

// File: rtl/sec_timer_pkg.sv
package sec_timer_pkg;

  typedef enum logic [1:0] {
    REG_MODE  = 2'd0,
    REG_ALARM = 2'd1,
    REG_COUNT = 2'd2,
    REG_EVT   = 2'd3
  } reg_sel_e;

  localparam int unsigned EVT_ALARM = 0;
  localparam int unsigned EVT_STEP  = 1;
  localparam int unsigned NUM_EVT   = 2;

endpackage

// File: rtl/sec_timer_div.sv
module sec_timer_div #(
  parameter int unsigned PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             tick,
  input  logic [PRE_W-1:0] period,
  output logic             step
);

  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] last;
  logic             at_last;

  // period 0 wraps to all ones here, giving a 2**PRE_W tick period
  assign last    = period - 1'b1;
  assign at_last = (div_q == last);
  assign step    = tick && at_last && !restart;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      div_q <= '0;
    end else if (tick) begin
      div_q <= at_last ? '0 : div_q + 1'b1;
    end
  end

endmodule

// File: rtl/sec_timer_cnt.sv
module sec_timer_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             step,
  input  logic [CNT_W-1:0] alarm,
  output logic [CNT_W-1:0] count,
  output logic             hit
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_next;

  assign cnt_next = cnt_q + 1'b1;
  // an all-ones alarm marks "no alarm armed"
  assign hit      = step && (cnt_next == alarm) && (alarm != '1);
  assign count    = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_next;
    end
  end

endmodule

// File: rtl/sec_timer_evt.sv
module sec_timer_evt #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         clr,
  input  logic [N-1:0] en_next,
  output logic [N-1:0] flags,
  output logic         irq
);

  logic [N-1:0] flag_q;
  logic [N-1:0] flag_d;
  logic         irq_q;

  for (genvar g = 0; g < N; g++) begin : g_flag
    // a set in the read cycle wins over the clear
    assign flag_d[g] = (flag_q[g] & ~clr) | set[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= |(flag_d & en_next);
    end
  end

  assign flags = flag_q;
  assign irq   = irq_q;

endmodule

// File: rtl/sec_timer.sv
module sec_timer
  import sec_timer_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned PRE_W   = 16,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned PRE_RST = 32768
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_tick_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);

  localparam int unsigned WORD_LSB = 2;
  localparam int unsigned EN_LSB   = PRE_W;
  localparam int unsigned RST_BIT  = PRE_W + NUM_EVT;

  reg_sel_e             reg_sel;
  logic                 wr_mode;
  logic                 wr_alarm;
  logic                 rd_any;
  logic                 rd_stat;
  logic                 restart;
  logic                 step;
  logic                 hit;
  logic [PRE_W-1:0]     presc_q;
  logic [NUM_EVT-1:0]   en_q;
  logic [NUM_EVT-1:0]   en_d;
  logic [CNT_W-1:0]     alarm_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [NUM_EVT-1:0]   evt_set;
  logic [NUM_EVT-1:0]   stat_q;
  logic [DATA_W-1:0]    rd_d;
  logic [DATA_W-1:0]    rdata_q;
  logic                 unused_addr;

  assign unused_addr = ^bus_addr_i[WORD_LSB-1:0];

  assign reg_sel  = reg_sel_e'(bus_addr_i[WORD_LSB +: 2]);
  assign wr_mode  = bus_sel_i && bus_wr_i && (reg_sel == REG_MODE);
  assign wr_alarm = bus_sel_i && bus_wr_i && (reg_sel == REG_ALARM);
  assign rd_any   = bus_sel_i && !bus_wr_i;
  assign rd_stat  = rd_any && (reg_sel == REG_EVT);
  assign restart  = wr_mode && bus_wdata_i[RST_BIT];
  assign en_d     = wr_mode ? bus_wdata_i[EN_LSB +: NUM_EVT] : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      presc_q <= PRE_W'(PRE_RST);
      en_q    <= '0;
      alarm_q <= '1;
    end else begin
      if (wr_mode) begin
        presc_q <= bus_wdata_i[PRE_W-1:0];
      end
      en_q <= en_d;
      if (wr_alarm) begin
        alarm_q <= bus_wdata_i[CNT_W-1:0];
      end
    end
  end

  sec_timer_div #(.PRE_W(PRE_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .tick    (slow_tick_i),
    .period  (presc_q),
    .step    (step)
  );

  sec_timer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .step    (step),
    .alarm   (alarm_q),
    .count   (cnt_q),
    .hit     (hit)
  );

  assign evt_set[EVT_ALARM] = hit;
  assign evt_set[EVT_STEP]  = step;

  sec_timer_evt #(.N(NUM_EVT)) u_evt (
    .clk     (clk),
    .rst     (rst),
    .set     (evt_set),
    .clr     (rd_stat),
    .en_next (en_d),
    .flags   (stat_q),
    .irq     (irq_o)
  );

  always_comb begin
    rd_d = '0;
    unique case (reg_sel)
      REG_MODE: begin
        rd_d[PRE_W-1:0]          = presc_q;
        rd_d[EN_LSB +: NUM_EVT]  = en_q;
      end
      REG_ALARM: rd_d[CNT_W-1:0]   = alarm_q;
      REG_COUNT: rd_d[CNT_W-1:0]   = cnt_q;
      REG_EVT:   rd_d[NUM_EVT-1:0] = stat_q;
      default:   rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_any) begin
      rdata_q <= rd_d;
    end
  end

  assign bus_rdata_o = rdata_q;

endmodule

// File: rtl/sec_timer_chk.sv
module sec_timer_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             restart,
  input logic             rd_stat,
  input logic             step,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] alarm,
  input logic [1:0]       stat,
  input logic [1:0]       en,
  input logic             irq
);

  // R4
  cnt_restart_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0));

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!restart && !step) |=> $stable(cnt));

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!restart && step) |=> (cnt == $past(cnt) + 1'b1));

  // R9
  evt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && !step) |=> (stat == 2'b00));

  // R8
  no_alarm_marker_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat[0]) |-> ($past(alarm) != '1));

  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (|(stat & en)));

  // R10
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (|(stat & en)) |-> irq);

endmodule

bind sec_timer sec_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .restart (restart),
  .rd_stat (rd_stat),
  .step    (step),
  .cnt     (cnt_q),
  .alarm   (alarm_q),
  .stat    (stat_q),
  .en      (en_q),
  .irq     (irq_o)
);

// File: tb/test_sec_timer.sv
module test_sec_timer;

  localparam int unsigned CW = 8;
  localparam logic [3:0] A_MODE  = 4'h0;
  localparam logic [3:0] A_ALARM = 4'h4;
  localparam logic [3:0] A_COUNT = 4'h8;
  localparam logic [3:0] A_EVT   = 4'hC;

  typedef struct packed {
    logic [15:0] presc;
    logic [15:0] nticks;
    logic [7:0]  alarm;
    logic [1:0]  en;
    logic [7:0]  cnt;
    logic [1:0]  st;
    logic        irq;
  } vec_t;

  // restart, N ticks at period P -> count floor(N/P) (R3, R7, R10)
  localparam vec_t VECS [6] = '{
    '{16'd4, 16'd10, 8'hFF, 2'b00, 8'd2, 2'b10, 1'b0},
    '{16'd3, 16'd9,  8'h03, 2'b01, 8'd3, 2'b11, 1'b1},
    '{16'd1, 16'd7,  8'h02, 2'b10, 8'd7, 2'b11, 1'b1},
    '{16'd5, 16'd4,  8'h00, 2'b11, 8'd0, 2'b00, 1'b0},
    '{16'd2, 16'd6,  8'h05, 2'b01, 8'd3, 2'b10, 1'b0},
    '{16'd2, 16'd8,  8'h04, 2'b10, 8'd4, 2'b11, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [31:0] rv;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  sec_timer #(.CNT_W(CW)) i_sec_timer (
    .clk         (clk),
    .rst         (rst),
    .slow_tick_i (tick),
    .bus_sel_i   (sel),
    .bus_wr_i    (wr),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk); sel = 1'b0; d = rdata;
  endtask

  task automatic give_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
    end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd0, 32'd1);
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd_reg(A_MODE, rv);  check("R1 mode", rv, 32'h0000_8000);
    rd_reg(A_ALARM, rv); check("R1 alarm", rv, 32'h0000_00FF);
    rd_reg(A_COUNT, rv); check("R1 count", rv, 32'd0);
    rd_reg(A_EVT, rv);   check("R1 events", rv, 32'd0);

    // R3 default period: 32768 ticks per step
    wr_reg(A_MODE, 32'h0004_8000);
    give_ticks(32767);
    rd_reg(A_COUNT, rv); check("R3 count before period", rv, 32'd0);
    give_ticks(1);
    rd_reg(A_COUNT, rv); check("R3 count after period", rv, 32'd1);
    rd_reg(A_EVT, rv);   check("R7 step flag", rv, 32'd2);

    // R4 restart bit and upper bits read 0; R2 low address bits ignored
    wr_reg(A_MODE, 32'hFFFF_FFFF);
    rd_reg(A_MODE, rv);  check("R4 mode readback", rv, 32'h0003_FFFF);
    rd_reg(4'h2, rv);    check("R2 address bits 1:0", rv, 32'h0003_FFFF);
    wr_reg(A_MODE, 32'h0004_0004);

    // R5 read-only registers
    give_ticks(8);
    wr_reg(A_COUNT, 32'h0000_0055);
    wr_reg(A_EVT, 32'h0000_0003);
    rd_reg(A_COUNT, rv); check("R5 count unchanged", rv, 32'd2);
    rd_reg(A_EVT, rv);   check("R5 events unchanged", rv, 32'd2);

    // R4 restart mid-period clears divider too
    wr_reg(A_MODE, 32'h0004_0004);
    give_ticks(6);
    rd_reg(A_COUNT, rv); check("R3 count mid", rv, 32'd1);
    wr_reg(A_MODE, 32'h0004_0004);
    rd_reg(A_EVT, rv);   check("R4 restart keeps events", rv, 32'd2);
    give_ticks(3);
    rd_reg(A_COUNT, rv); check("R4 divider cleared", rv, 32'd0);
    give_ticks(1);
    rd_reg(A_COUNT, rv); check("R4 first step after restart", rv, 32'd1);
    rd_reg(A_EVT, rv);

    // R9 event on the read edge survives the clear
    wr_reg(A_MODE, 32'h0004_0001);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = A_EVT; tick = 1'b1;
    @(negedge clk); sel = 1'b0; tick = 1'b0; rv = rdata;
    check("R9 read value", rv, 32'd0);
    rd_reg(A_EVT, rv);   check("R9 event survives", rv, 32'd2);
    rd_reg(A_EVT, rv);   check("R9 cleared by read", rv, 32'd0);

    // R6 wrap, R8 all-ones alarm
    wr_reg(A_ALARM, 32'h0000_00FF);
    wr_reg(A_MODE, 32'h0004_0001);
    give_ticks(255);
    rd_reg(A_COUNT, rv); check("R6 count at max", rv, 32'h0000_00FF);
    rd_reg(A_EVT, rv);   check("R8 no alarm at all ones", rv, 32'd2);
    wr_reg(A_ALARM, 32'h0000_0000);
    give_ticks(1);
    rd_reg(A_COUNT, rv); check("R6 wrap to zero", rv, 32'd0);
    rd_reg(A_EVT, rv);   check("R7 alarm on wrap", rv, 32'd3);

    // R10 interrupt follows enable writes
    wr_reg(A_ALARM, 32'h0000_0002);
    wr_reg(A_MODE, 32'h0005_0001);
    give_ticks(2);
    check("R10 alarm irq", {31'd0, irq}, 32'd1);
    wr_reg(A_MODE, 32'h0000_0001);
    check("R10 irq off with enables", {31'd0, irq}, 32'd0);
    wr_reg(A_MODE, 32'h0002_0001);
    check("R10 step irq", {31'd0, irq}, 32'd1);
    rd_reg(A_EVT, rv);   check("R7 both flags", rv, 32'd3);
    check("R9 irq after clear", {31'd0, irq}, 32'd0);

    // vector table
    for (int k = 0; k < 6; k++) begin
      wr_reg(A_ALARM, {24'd0, VECS[k].alarm});
      wr_reg(A_MODE, {13'd0, 1'b1, VECS[k].en, VECS[k].presc});
      give_ticks(int'(VECS[k].nticks));
      check("R10 vector irq", {31'd0, irq}, {31'd0, VECS[k].irq});
      rd_reg(A_COUNT, rv); check("R3 vector count", rv, {24'd0, VECS[k].cnt});
      rd_reg(A_EVT, rv);   check("R7 vector events", rv, {30'd0, VECS[k].st});
      check("R9 vector irq cleared", {31'd0, irq}, 32'd0);
    end

    report();
  end

endmodule